// File: doc/BRIEF.md
# Flag-conditioned floating-point register select

This block executes a conditional register-select operation for a floating-point unit. Each issued 32-bit instruction word is decoded. If it belongs to the block's opcode group and carries the select pattern, the block evaluates one of four conditions on the N, Z and V flags. It then copies one of two source registers into a destination register without altering the bits. The copy is bit-for-bit, so the block performs no rounding, conversion or NaN handling.

A size bit switches the same datapath between two views of the register file. In the double view there are 32 registers of 64 bits. In the single view there are 32 registers of 32 bits, and each pair of them shares one 64-bit entry. The block reads the register file through two combinational read ports: one returns the chosen source and the other returns the destination entry. It writes the result through a single 64-bit write port, one cycle after issue. Any other encoding inside the opcode group is reported as undefined, and in that case nothing is written.

Top module: `fp_cond_select`

## Requirements
- R1: An issued word with bits 31:23 = 9'h1FC, bits 11:9 = 3'b101, bit 6 = 0 and bit 4 = 0 is accepted. On the next rising clock edge `wr_en` is high for one cycle and `undef` is low.
- R2: An issued word with bits 31:23 = 9'h1FC that fails any of the other pattern bits raises `undef` for one cycle after the next edge and keeps `wr_en` low.
- R3: A word outside the opcode group, or any word presented while `issue_valid` is low, produces neither `wr_en` nor `undef`.
- R4: Bits 21:20 pick the condition: 2'b00 holds when Z=1; 2'b01 holds when V=1; 2'b10 holds when N equals V; 2'b11 holds when Z=0 and N equals V.
- R5: When the condition holds, the destination receives operand A (field Vn). Otherwise it receives operand B (field Vm).
- R6: When bit 8 = 1 (double view), each register index is the extra bit above its 4-bit field: dest {bit22, bits15:12}, A {bit7, bits19:16}, B {bit5, bits3:0}. `wr_idx` equals the destination index.
- R7: When bit 8 = 0 (single view), each index is the 4-bit field above the extra bit: dest {bits15:12, bit22}, A {bits19:16, bit7}, B {bits3:0, bit5}. Single register s lives in 64-bit entry s>>1, in bits 31:0 when s is even and in bits 63:32 when s is odd.
- R8: A single-view write carries the untouched half of the destination entry unchanged in `wr_data`, including when the destination aliases a source.
- R9: The selected value reaches `wr_data` unmodified, with all bits identical to the source.
- R10: After reset, and until the first accepted or rejected issue, `wr_en` and `undef` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| src_ridx | output | 5 | 64-bit entry index of the selected source |
| src_rdata | input | 64 | Combinational read data for `src_ridx` |
| dst_ridx | output | 5 | 64-bit entry index of the destination |
| dst_rdata | input | 64 | Combinational read data for `dst_ridx` |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | 64-bit entry index to write |
| wr_data | output | 64 | Full 64-bit entry to write |
| undef | output | 1 | Undefined-encoding indication |

## Verification
The read indices are combinational, so they are valid in the cycle an instruction is presented. `wr_en`, `wr_idx`, `wr_data` and `undef` all change at the first rising edge after issue. The bench drives each instruction at a falling edge, lets exactly one rising edge pass, and samples every registered output at the following falling edge. It then lowers `issue_valid`. It also applies the write to its own register model at that point, which keeps the read ports stable across the sampling edge and lets aliased destinations be checked against the value written just before.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

   localparam int unsigned RIDX_W = 5;

   typedef enum logic [1:0] {
      CC_ZSET = 2'b00,
      CC_VSET = 2'b01,
      CC_NEQV = 2'b10,
      CC_ABOV = 2'b11
   } sel_cond_e;

   typedef struct packed {
      logic              in_group;
      logic              legal;
      sel_cond_e         cond;
      logic              dbl;
      logic [RIDX_W-1:0] dst;
      logic [RIDX_W-1:0] opa;
      logic [RIDX_W-1:0] opb;
   } sel_decode_t;

   // double view: extra bit on top; single view: extra bit at the bottom
   function automatic logic [RIDX_W-1:0] form_idx(input logic dbl,
                                                   input logic [3:0] fld,
                                                   input logic ext);
      return dbl ? {ext, fld} : {fld, ext};
   endfunction

endpackage

// File: rtl/fpsel_decode.sv
module fpsel_decode
   import fpsel_pkg::*;
#(
   parameter int unsigned GROUP_HI   = 31,
   parameter int unsigned GROUP_LO   = 23,
   parameter logic [8:0]  GROUP_CODE = 9'h1FC,
   parameter logic [2:0]  KIND_CODE  = 3'b101
) (
   input  logic [31:0] instr,
   output sel_decode_t dec
);
   localparam int unsigned GROUP_W = GROUP_HI - GROUP_LO + 1;

   if (GROUP_W != 9) begin : g_bad_group
      $error("fpsel_decode: group field must be 9 bits wide");
   end

   logic [GROUP_W-1:0] grp;
   logic               kind_ok;
   logic               fixed_ok;

   assign grp      = instr[GROUP_HI:GROUP_LO];
   assign kind_ok  = (instr[11:9] == KIND_CODE);
   assign fixed_ok = (instr[6] == 1'b0) && (instr[4] == 1'b0);

   always_comb begin
      dec          = '0;
      dec.in_group = (grp == GROUP_CODE[GROUP_W-1:0]);
      dec.legal    = kind_ok && fixed_ok;
      dec.cond     = sel_cond_e'(instr[21:20]);
      dec.dbl      = instr[8];
      dec.dst      = form_idx(instr[8], instr[15:12], instr[22]);
      dec.opa      = form_idx(instr[8], instr[19:16], instr[7]);
      dec.opb      = form_idx(instr[8], instr[3:0],   instr[5]);
   end

endmodule

// File: rtl/fpsel_cond.sv
module fpsel_cond
   import fpsel_pkg::*;
(
   input  sel_cond_e cond,
   input  logic      fn,
   input  logic      fz,
   input  logic      fv,
   output logic      holds
);
   logic sign_ok;

   assign sign_ok = (fn == fv);

   always_comb begin
      unique case (cond)
         CC_ZSET: holds = fz;
         CC_VSET: holds = fv;
         CC_NEQV: holds = sign_ok;
         CC_ABOV: holds = sign_ok && !fz;
      endcase
   end

endmodule

// File: rtl/fpsel_merge.sv
module fpsel_merge #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              dbl,
   input  logic              src_hi,
   input  logic              dst_hi,
   input  logic [DATA_W-1:0] src_entry,
   input  logic [DATA_W-1:0] dst_entry,
   output logic [DATA_W-1:0] result
);
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned LANES  = 2;

   logic [HALF_W-1:0] src_half;

   assign src_half = src_hi ? src_entry[DATA_W-1:HALF_W] : src_entry[HALF_W-1:0];

   for (genvar h = 0; h < LANES; h++) begin : g_lane
      logic target;
      assign target = (dst_hi == (h == 1));
      always_comb begin
         if (dbl)
            result[h*HALF_W +: HALF_W] = src_entry[h*HALF_W +: HALF_W];
         else if (target)
            result[h*HALF_W +: HALF_W] = src_half;
         else
            result[h*HALF_W +: HALF_W] = dst_entry[h*HALF_W +: HALF_W];
      end
   end

endmodule

// File: rtl/fp_cond_select.sv
module fp_cond_select
   import fpsel_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter logic [8:0]  GROUP_CODE = 9'h1FC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_valid,
   input  logic [31:0]          instr,
   input  logic                 flag_n,
   input  logic                 flag_z,
   input  logic                 flag_v,
   output logic [RIDX_W-1:0]    src_ridx,
   input  logic [DATA_W-1:0]    src_rdata,
   output logic [RIDX_W-1:0]    dst_ridx,
   input  logic [DATA_W-1:0]    dst_rdata,
   output logic                 wr_en,
   output logic [RIDX_W-1:0]    wr_idx,
   output logic [DATA_W-1:0]    wr_data,
   output logic                 undef
);
   localparam int unsigned HALF_W = DATA_W / 2;

   if ((DATA_W % 2) != 0 || DATA_W < 2) begin : g_bad_width
      $error("fp_cond_select: DATA_W must be even and at least 2");
   end

   sel_decode_t       dec;
   logic              holds;
   logic [RIDX_W-1:0] pick;
   logic [DATA_W-1:0] merged;
   logic              accept;
   logic              reject;

   fpsel_decode #(
      .GROUP_CODE (GROUP_CODE)
   ) i_decode (
      .instr (instr),
      .dec   (dec)
   );

   fpsel_cond i_cond (
      .cond  (dec.cond),
      .fn    (flag_n),
      .fz    (flag_z),
      .fv    (flag_v),
      .holds (holds)
   );

   assign pick     = holds ? dec.opa : dec.opb;
   assign src_ridx = dec.dbl ? pick    : {1'b0, pick[RIDX_W-1:1]};
   assign dst_ridx = dec.dbl ? dec.dst : {1'b0, dec.dst[RIDX_W-1:1]};

   fpsel_merge #(
      .DATA_W (DATA_W)
   ) i_merge (
      .dbl       (dec.dbl),
      .src_hi    (pick[0]),
      .dst_hi    (dec.dst[0]),
      .src_entry (src_rdata),
      .dst_entry (dst_rdata),
      .result    (merged)
   );

   assign accept = issue_valid && dec.in_group && dec.legal;
   assign reject = issue_valid && dec.in_group && !dec.legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         undef   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en   <= accept;
         undef   <= reject;
         if (accept) begin
            wr_idx  <= dst_ridx;
            wr_data <= merged;
         end
      end
   end

   logic unused_half;
   assign unused_half = (HALF_W == 0);

endmodule

// File: rtl/fpsel_checker.sv
module fpsel_checker
   import fpsel_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic [31:0]       instr,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_v,
   input logic [RIDX_W-1:0] src_ridx,
   input logic [DATA_W-1:0] src_rdata,
   input logic [RIDX_W-1:0] dst_ridx,
   input logic [DATA_W-1:0] dst_rdata,
   input logic              wr_en,
   input logic [RIDX_W-1:0] wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              undef
);
   localparam int unsigned HALF_W = DATA_W / 2;

   logic grp_hit;
   logic pat_ok;
   assign grp_hit = issue_valid && (instr[31:23] == 9'h1FC);
   assign pat_ok  = (instr[11:9] == 3'b101) && !instr[6] && !instr[4];

   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit && pat_ok |=> wr_en && !undef);

   p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit && !pat_ok |=> undef && !wr_en);

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_hit |=> !wr_en && !undef);

   p_zset_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit && pat_ok && instr[8] && instr[21:20] == 2'b00 && flag_z
      |-> src_ridx == {instr[7], instr[19:16]});

   p_dbl_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit && pat_ok && instr[8] |=> wr_idx == {$past(instr[22]), $past(instr[15:12])});

   p_keep_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit && pat_ok && !instr[8] && !instr[22]
      |=> wr_data[DATA_W-1:HALF_W] == $past(dst_rdata[DATA_W-1:HALF_W]));

   p_keep_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit && pat_ok && !instr[8] && instr[22]
      |=> wr_data[HALF_W-1:0] == $past(dst_rdata[HALF_W-1:0]));

   p_exact_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit && pat_ok && instr[8] |=> wr_data == $past(src_rdata));

   p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && undef));

endmodule

bind fp_cond_select fpsel_checker #(.DATA_W(DATA_W)) i_fpsel_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .instr       (instr),
   .flag_n      (flag_n),
   .flag_z      (flag_z),
   .flag_v      (flag_v),
   .src_ridx    (src_ridx),
   .src_rdata   (src_rdata),
   .dst_ridx    (dst_ridx),
   .dst_rdata   (dst_rdata),
   .wr_en       (wr_en),
   .wr_idx      (wr_idx),
   .wr_data     (wr_data),
   .undef       (undef)
);

// File: tb/test_fp_cond_select.sv
`timescale 1ns/1ps
module test_fp_cond_select;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [31:0] instr = '0;
   logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0;
   logic [4:0]  src_ridx, dst_ridx, wr_idx;
   logic [63:0] src_rdata, dst_rdata, wr_data;
   logic        wr_en, undef;

   logic [63:0] rf [32];
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   assign src_rdata = rf[src_ridx];
   assign dst_rdata = rf[dst_ridx];

   fp_cond_select i_fp_cond_select (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
      .src_ridx(src_ridx), .src_rdata(src_rdata),
      .dst_ridx(dst_ridx), .dst_rdata(dst_rdata),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .undef(undef)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit sz, input logic [1:0] cc,
                                      input logic [4:0] d, input logic [4:0] n,
                                      input logic [4:0] m);
      logic [31:0] w = 32'h0;
      w[31:23] = 9'h1FC; w[21:20] = cc; w[11:9] = 3'b101; w[8] = sz;
      if (sz) begin
         w[22] = d[4]; w[15:12] = d[3:0]; w[7] = n[4]; w[19:16] = n[3:0];
         w[5] = m[4];  w[3:0] = m[3:0];
      end else begin
         w[22] = d[0]; w[15:12] = d[4:1]; w[7] = n[0]; w[19:16] = n[4:1];
         w[5] = m[0];  w[3:0] = m[4:1];
      end
      return w;
   endfunction

   function automatic bit cond_true(input logic [1:0] cc, input logic [3:0] f);
      // f = {unused, n, z, v}
      case (cc)
         2'd0: return f[1];
         2'd1: return f[0];
         2'd2: return f[2] == f[0];
         default: return (f[2] == f[0]) && !f[1];
      endcase
   endfunction

   task automatic issue(input logic [31:0] w, input logic [3:0] f);
      @(negedge clk);
      instr = w; flag_n = f[2]; flag_z = f[1]; flag_v = f[0];
      issue_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic run_sel(input bit sz, input logic [1:0] cc, input logic [4:0] d,
                          input logic [4:0] n, input logic [4:0] m,
                          input logic [3:0] f, input string req);
      logic [4:0]  s;
      logic [4:0]  eidx;
      logic [63:0] edat;
      logic [31:0] h;
      s = cond_true(cc, f) ? n : m;
      if (sz) begin
         eidx = d;
         edat = rf[s];
      end else begin
         eidx = {1'b0, d[4:1]};
         h    = s[0] ? rf[s[4:1]][63:32] : rf[s[4:1]][31:0];
         edat = rf[eidx];
         if (d[0]) edat[63:32] = h; else edat[31:0] = h;
      end
      issue(mk(sz, cc, d, n, m), f);
      chk(wr_en === 1'b1 && undef === 1'b0, "R1", "accept strobe",
          {62'h0, wr_en, undef}, 64'h2);
      chk(wr_idx === eidx, sz ? "R6" : "R7", "write index", 64'(wr_idx), 64'(eidx));
      chk(wr_data === edat, req, "write data", wr_data, edat);
      if (wr_en === 1'b1) rf[wr_idx] = wr_data;
   endtask

   task automatic run_bad(input logic [31:0] w, input bit exp_ud, input bit valid,
                          input string req);
      @(negedge clk);
      instr = w; flag_n = 1'b0; flag_z = 1'b1; flag_v = 1'b1;
      issue_valid = valid;
      @(posedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      chk(wr_en === 1'b0 && undef === exp_ud, req, "reject strobes",
          {62'h0, wr_en, undef}, {63'h0, exp_ud});
      if (wr_en === 1'b1) rf[wr_idx] = wr_data;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] good;
      for (int i = 0; i < 32; i++)
         rf[i] = {32'(i * 32'h9E3779B9) ^ 32'h5A5AC3C3, 32'(i * 32'h85EBCA6B + 32'h17)};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(wr_en === 1'b0 && undef === 1'b0, "R10", "reset strobes",
          {62'h0, wr_en, undef}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_en === 1'b0 && undef === 1'b0, "R10", "idle after reset",
          {62'h0, wr_en, undef}, 64'h0);

      // R4 R5 R9: every flag combination against every condition, both views
      for (int p = 0; p < 2; p++)
         for (int c = 0; c < 4; c++)
            for (int f = 0; f < 16; f++) begin
               logic [4:0] dd, nn, mm;
               dd = 5'((f * 7 + c * 3 + p * 11) % 32);
               nn = 5'((f * 5 + c + 9) % 32);
               mm = nn ^ 5'd19;
               run_sel(p[0], c[1:0], dd, nn, mm, f[3:0], "R4/R5 R9");
            end

      // R8: single-view aliasing of destination with each operand, both halves
      for (int c = 0; c < 4; c++)
         for (int f = 0; f < 8; f++) begin
            run_sel(1'b0, c[1:0], 5'd6, 5'd6, 5'd13, f[3:0], "R8 alias A");
            run_sel(1'b0, c[1:0], 5'd13, 5'd7, 5'd13, f[3:0], "R8 alias B");
            run_sel(1'b0, c[1:0], 5'd20, 5'd21, 5'd21, f[3:0], "R8 pair");
            run_sel(1'b1, c[1:0], 5'd30, 5'd30, 5'd3, f[3:0], "R6 alias");
         end

      // R2: broken pattern bits inside the group
      good = mk(1'b1, 2'd0, 5'd1, 5'd2, 5'd3);
      run_bad(good | 32'h0000_0040, 1'b1, 1'b1, "R2 bit6");
      run_bad(good | 32'h0000_0010, 1'b1, 1'b1, "R2 bit4");
      for (int k = 0; k < 8; k++)
         if (k != 5) begin
            logic [31:0] w;
            w = good;
            w[11:9] = k[2:0];
            run_bad(w, 1'b1, 1'b1, "R2 kind");
         end

      // R3: outside the group, or not issued
      run_bad(good ^ 32'h0080_0000, 1'b0, 1'b1, "R3 group");
      run_bad(good ^ 32'h1000_0000, 1'b0, 1'b1, "R3 group top");
      run_bad(good, 1'b0, 1'b0, "R3 no issue");
      run_bad(good | 32'h0000_0040, 1'b0, 1'b0, "R3 no issue bad");

      // R1: back-to-back accept after rejects still writes
      run_sel(1'b1, 2'd3, 5'd31, 5'd0, 5'd17, 4'b0000, "R1 R5");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule